// File: doc/BRIEF.md
# Alarm Real-Time Counter

This block is a real-time counter with two compare alarms, accessed through a simple 32-bit register bus. A slow reference clock, typically 32768 Hz, enters asynchronously. It is brought into the bus clock domain by a two-flop synchronizer, and its rising edges are found there. A programmable divider turns those edges into counter ticks. Because the counter and all state live in the bus domain, a read never returns a value that is torn across bits.

Software chooses the tick rate through the divider register and starts counting by writing the run code to the clock-source select register. It arms one or both alarms by writing a compare value and setting the matching enable bit in the status word. The interrupt output stays high while any enabled event is pending. Software acknowledges an event by writing a one to its event bit. A scratch register is kept for software, for example to hold the number of times the counter has wrapped.

Top module: `rtcc_top`

## Requirements
- R1: After reset, the counter, both alarm registers, the status word and the scratch register read 0, the divider reads 1023, the clock-source select reads 0, and `irq_o` is low.
- R2: While the clock-source select holds 3, the counter increases by one once every 2×(DIV+1) synchronized rising edges of `ref_clk_i`, where DIV is the divider register value.
- R3: Any clock-source select value other than 3 stops the counter and restarts the divider phase.
- R4: A bus write to offset 0x00 loads the counter in any cycle and takes priority over a tick in that cycle; the counter wraps from 0xFFFFFFFF to 0.
- R5: Status bit 0 (alarm-0 event) sets one cycle after the counter becomes equal to the alarm-0 register (offset 0x04) while status bit 2 (alarm-0 enable) is 1. It does not set while bit 2 is 0.
- R6: Alarm 1 behaves in the same way, using the register at offset 0x18, status bit 4 as its event and status bit 6 as its enable.
- R7: Status bit 1 (tick event) sets on every tick while status bit 3 (tick enable) is 1.
- R8: Event bits 0, 1 and 4 clear when a one is written to them and keep their value when a zero is written. A set in the same cycle wins over the clear. Enable bits 2, 3 and 6 are plain read/write bits. Bits 5 and 7 to 31 read 0.
- R9: `irq_o` is high exactly when at least one event bit is set together with its enable bit.
- R10: The scratch register at offset 0x40 reads back what was written and has no effect on counting.
- R11: The divider (offset 0x0C) stores and returns the low 16 bits of a write. The clock-source select (offset 0x1C) stores and returns the low 2 bits. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt, high while an enabled event is pending |

## Verification
The counter is run at two divider settings, and the spacing between its steps is measured in bus cycles. This separates a correct half-period formula from an off-by-one in the divider and from a reference edge that is counted twice. Alarms are armed with their enables both set and cleared, and the counter is preloaded just below 0xFFFFFFFF. These cases separate a level compare from a crossing compare, show whether the enable gates the event, and exercise the wrap. Write-one-to-clear is probed with both zero and one in the event bits, and a behavioural model checks the read data and the interrupt on every cycle.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
   localparam int NUM_ALM = 2;

   localparam logic [7:0] OFF_CNT  = 8'h00;
   localparam logic [7:0] OFF_STAT = 8'h08;
   localparam logic [7:0] OFF_DIV  = 8'h0C;
   localparam logic [7:0] OFF_CSEL = 8'h1C;
   localparam logic [7:0] OFF_SCR  = 8'h40;

   localparam int TICK_EV_BIT = 1;
   localparam int TICK_EN_BIT = 3;

   function automatic logic [7:0] alm_off(input int idx);
      return (idx == 0) ? 8'h04 : 8'h18;
   endfunction

   function automatic int alm_ev_bit(input int idx);
      return (idx == 0) ? 0 : 4;
   endfunction

   function automatic int alm_en_bit(input int idx);
      return (idx == 0) ? 2 : 6;
   endfunction
endpackage

// File: rtl/rtcc_refsync.sv
module rtcc_refsync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_clk_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtcc_refsync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], ref_clk_i};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R2
   single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/rtcc_divider.sv
module rtcc_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             rise_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   localparam int PH_W = DIV_W + 1;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] limit;
   logic            at_limit;

   assign limit    = {div_i, 1'b1};
   assign at_limit = (phase_q >= limit);
   assign tick_o   = run_i & rise_i & at_limit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           phase_q <= '0;
      else if (!run_i)       phase_q <= '0;
      else if (rise_i) begin
         if (at_limit)       phase_q <= '0;
         else                phase_q <= phase_q + PH_W'(1);
      end
   end

   // R3
   stopped_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> phase_q == '0);
endmodule

// File: rtl/rtcc_alarm_cmp.sv
module rtcc_alarm_cmp #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             hit_o
);
   logic match, match_q;

   assign match = (cnt_i == cmp_i);
   assign hit_o = en_i & match & ~match_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q <= 1'b0;
      else         match_q <= match;
   end
endmodule

// File: rtl/rtcc_top.sv
module rtcc_top #(
   parameter int ADDR_W      = 8,
   parameter int CNT_W       = 32,
   parameter int DIV_W       = 16,
   parameter int DIV_RST     = 1023,
   parameter int CSEL_W      = 2,
   parameter int CSEL_RUN    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ref_clk_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o
);
   import rtcc_pkg::*;

   localparam int DATA_W = 32;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("rtcc_top: CNT_W out of range");
      end
      if (DIV_W < 1 || DIV_W > 30) begin : g_bad_div
         $error("rtcc_top: DIV_W out of range");
      end
      if (DIV_RST >= (1 << DIV_W)) begin : g_bad_divrst
         $error("rtcc_top: DIV_RST does not fit DIV_W");
      end
      if (CSEL_RUN >= (1 << CSEL_W)) begin : g_bad_csel
         $error("rtcc_top: CSEL_RUN does not fit CSEL_W");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("rtcc_top: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  alm_q  [NUM_ALM];
   logic [NUM_ALM-1:0] alm_ev_q, alm_en_q, alm_hit;
   logic              tick_ev_q, tick_en_q;
   logic [DIV_W-1:0]  div_q;
   logic [CSEL_W-1:0] csel_q;
   logic [DATA_W-1:0] scr_q;

   logic rise, tick, run;
   logic cnt_wr, stat_wr, div_wr, csel_wr, scr_wr;

   assign cnt_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_CNT));
   assign stat_wr = wr_en_i && (addr_i == ADDR_W'(OFF_STAT));
   assign div_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_DIV));
   assign csel_wr = wr_en_i && (addr_i == ADDR_W'(OFF_CSEL));
   assign scr_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_SCR));
   assign run     = (csel_q == CSEL_W'(CSEL_RUN));

   rtcc_refsync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i), .rise_o(rise));

   rtcc_divider #(.DIV_W(DIV_W)) i_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .rise_i(rise),
      .div_i(div_q), .tick_o(tick));

   // counter and plain registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         div_q  <= DIV_W'(DIV_RST);
         csel_q <= '0;
         scr_q  <= '0;
      end else begin
         if (cnt_wr)       cnt_q <= wdata_i[CNT_W-1:0];
         else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
         if (div_wr)       div_q  <= wdata_i[DIV_W-1:0];
         if (csel_wr)      csel_q <= wdata_i[CSEL_W-1:0];
         if (scr_wr)       scr_q  <= wdata_i;
      end
   end

   // alarm channels
   generate
      for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
         localparam int EVB = alm_ev_bit(g);
         localparam int ENB = alm_en_bit(g);
         logic cmp_wr;
         assign cmp_wr = wr_en_i && (addr_i == ADDR_W'(alm_off(g)));

         rtcc_alarm_cmp #(.CNT_W(CNT_W)) i_cmp (
            .clk_i(clk_i), .rst_ni(rst_ni), .en_i(alm_en_q[g]),
            .cnt_i(cnt_q), .cmp_i(alm_q[g]), .hit_o(alm_hit[g]));

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               alm_q[g]    <= '0;
               alm_ev_q[g] <= 1'b0;
               alm_en_q[g] <= 1'b0;
            end else begin
               if (cmp_wr)  alm_q[g] <= wdata_i[CNT_W-1:0];
               alm_ev_q[g] <= alm_hit[g] | (alm_ev_q[g] & ~(stat_wr & wdata_i[EVB]));
               if (stat_wr) alm_en_q[g] <= wdata_i[ENB];
            end
         end

         // R5
         ev_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(alm_ev_q[g]) |-> $past(alm_en_q[g]));
         // R8
         ev_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_wr && wdata_i[EVB] && !alm_hit[g]) |=> !alm_ev_q[g]);
      end
   endgenerate

   // periodic tick event
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_ev_q <= 1'b0;
         tick_en_q <= 1'b0;
      end else begin
         tick_ev_q <= (tick & tick_en_q) |
                      (tick_ev_q & ~(stat_wr & wdata_i[TICK_EV_BIT]));
         if (stat_wr) tick_en_q <= wdata_i[TICK_EN_BIT];
      end
   end

   // status word and read mux
   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = '0;
      stat_word[TICK_EV_BIT] = tick_ev_q;
      stat_word[TICK_EN_BIT] = tick_en_q;
      for (int k = 0; k < NUM_ALM; k++) begin
         stat_word[alm_ev_bit(k)] = alm_ev_q[k];
         stat_word[alm_en_bit(k)] = alm_en_q[k];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(OFF_CNT))  rdata_o = DATA_W'(cnt_q);
      if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = stat_word;
      if (addr_i == ADDR_W'(OFF_DIV))  rdata_o = DATA_W'(div_q);
      if (addr_i == ADDR_W'(OFF_CSEL)) rdata_o = DATA_W'(csel_q);
      if (addr_i == ADDR_W'(OFF_SCR))  rdata_o = scr_q;
      for (int k = 0; k < NUM_ALM; k++)
         if (addr_i == ADDR_W'(alm_off(k))) rdata_o = DATA_W'(alm_q[k]);
   end

   assign irq_o = (|(alm_ev_q & alm_en_q)) | (tick_ev_q & tick_en_q);

   // R2
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && !cnt_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
   // R3
   cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !cnt_wr) |=> $stable(cnt_q));
   // R4
   cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_wr |=> cnt_q == $past(wdata_i[CNT_W-1:0]));
   // R7
   tick_ev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && tick_en_q) |=> tick_ev_q);
endmodule

// File: tb/test_rtcc_top.sv
module test_rtcc_top;
   localparam int REF_HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   rtcc_top i_rtcc_top (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

   // free-running slow reference
   int ref_ph = 0;
   always @(negedge clk) begin
      ref_ph = ref_ph + 1;
      if (ref_ph == REF_HALF) begin
         ref_ph = 0;
         ref_clk = ~ref_clk;
      end
   end

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_cnt, m_scr;
   logic [31:0] m_al [2];
   int          m_div, m_csel, m_phase;
   bit          m_ev [2], m_en [2], m_mprev [2];
   bit          m_tev, m_ten;
   bit          h1, h2, h3;

   function automatic int evb(int i); return i == 0 ? 0 : 4; endfunction
   function automatic int enb(int i); return i == 0 ? 2 : 6; endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_scr = 0; m_div = 1023; m_csel = 0; m_phase = 0;
         m_tev = 0; m_ten = 0; h1 = 0; h2 = 0; h3 = 0;
         for (int i = 0; i < 2; i++) begin
            m_al[i] = 0; m_ev[i] = 0; m_en[i] = 0; m_mprev[i] = 0;
         end
      end else begin
         bit pulse, tk, sw;
         bit hit [2];
         pulse = h2 && !h3;
         h3 = h2; h2 = h1; h1 = ref_clk;
         tk = 0;
         if (m_csel == 3) begin
            if (pulse) begin
               if (m_phase >= 2 * m_div + 1) begin tk = 1; m_phase = 0; end
               else m_phase = m_phase + 1;
            end
         end else m_phase = 0;
         for (int i = 0; i < 2; i++) begin
            bit mt;
            mt = (m_cnt == m_al[i]);
            hit[i] = m_en[i] && mt && !m_mprev[i];
            m_mprev[i] = mt;
         end
         sw = wr_en && addr == 8'h08;
         for (int i = 0; i < 2; i++) begin
            m_ev[i] = hit[i] || (m_ev[i] && !(sw && wdata[evb(i)]));
            if (sw) m_en[i] = wdata[enb(i)];
         end
         m_tev = (tk && m_ten) || (m_tev && !(sw && wdata[1]));
         if (sw) m_ten = wdata[3];
         if (wr_en && addr == 8'h00) m_cnt = wdata;
         else if (tk) m_cnt = m_cnt + 1;
         if (wr_en && addr == 8'h04) m_al[0] = wdata;
         if (wr_en && addr == 8'h18) m_al[1] = wdata;
         if (wr_en && addr == 8'h0C) m_div = int'(wdata[15:0]);
         if (wr_en && addr == 8'h1C) m_csel = int'(wdata[1:0]);
         if (wr_en && addr == 8'h40) m_scr = wdata;
      end
   end

   function automatic logic [31:0] m_read(logic [7:0] a);
      case (a)
         8'h00: return m_cnt;
         8'h04: return m_al[0];
         8'h18: return m_al[1];
         8'h08: return {25'b0, m_en[1], 1'b0, m_ev[1], m_ten, m_en[0], m_tev, m_ev[0]};
         8'h0C: return 32'(m_div);
         8'h1C: return 32'(m_csel);
         8'h40: return m_scr;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit m_irq();
      return (m_ev[0] && m_en[0]) || (m_ev[1] && m_en[1]) || (m_tev && m_ten);
   endfunction

   // ---------------- checking helpers ----------------
   task automatic report(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic string tag_for(logic [7:0] a);
      if (a == 8'h00) return "R2";
      if (a == 8'h08) return "R8";
      return "R11";
   endfunction

   // one bus cycle, comparing with the model away from the clock edge
   task automatic cyc();
      @(negedge clk);
      #1;
      if (rst_n) begin
         report(tag_for(addr), rdata, m_read(addr));
         report("R9", 32'(irq), 32'(m_irq()));
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      cyc();
      wr_en = 1'b1; addr = a; wdata = d;
      cyc();
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic chk(logic [7:0] a, logic [31:0] exp, string req);
      cyc();
      addr = a;
      #1;
      report(req, rdata, exp);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   // measure bus cycles between two counter steps
   task automatic measure(int exp, string req);
      logic [31:0] prev;
      int n, guard;
      cyc(); addr = 8'h00; #1;
      prev = rdata; guard = 0;
      while (rdata == prev && guard < 20000) begin cyc(); guard++; end
      prev = rdata; n = 0;
      while (rdata == prev && n < 20000) begin cyc(); n++; end
      report(req, 32'(n), 32'(exp));
   endtask

   task automatic wait_irq(int limit, string req);
      int n;
      n = 0;
      while (!irq && n < limit) begin cyc(); n++; end
      report(req, 32'(irq), 32'h1);
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(8'h00, 32'h0, "R1");
      chk(8'h04, 32'h0, "R1");
      chk(8'h18, 32'h0, "R1");
      chk(8'h08, 32'h0, "R1");
      chk(8'h40, 32'h0, "R1");
      chk(8'h0C, 32'd1023, "R1");
      chk(8'h1C, 32'h0, "R1");
      report("R1", 32'(irq), 32'h0);

      // R3 stopped while select is not 3
      wr(8'h0C, 32'd0);
      wr(8'h1C, 32'd2);
      idle(100);
      chk(8'h00, 32'h0, "R3");

      // R2 tick spacing at two divider values
      wr(8'h0C, 32'd2);
      wr(8'h1C, 32'd3);
      measure(2 * 3 * 2 * REF_HALF, "R2");
      wr(8'h0C, 32'd0);
      measure(2 * 1 * 2 * REF_HALF, "R2");

      // R10 scratch does not disturb counting
      wr(8'h40, 32'hDEADBEEF);
      chk(8'h40, 32'hDEADBEEF, "R10");
      measure(2 * 1 * 2 * REF_HALF, "R10");

      // R3 stop holds the value
      wr(8'h1C, 32'd1);
      wr(8'h00, 32'h1234);
      idle(80);
      chk(8'h00, 32'h1234, "R3");

      // R4 wrap
      wr(8'h00, 32'hFFFF_FFFE);
      wr(8'h1C, 32'd3);
      begin
         int n;
         n = 0;
         cyc(); addr = 8'h00; #1;
         while (rdata != 32'hFFFF_FFFF && n < 200) begin cyc(); n++; end
         report("R4", rdata, 32'hFFFF_FFFF);
         n = 0;
         while (rdata == 32'hFFFF_FFFF && n < 200) begin cyc(); n++; end
         report("R4", rdata, 32'h0);
      end

      // R5 alarm 0 disabled: no event
      wr(8'h04, 32'd3);
      idle(100);
      chk(8'h08, 32'h0, "R5");
      // R5 alarm 0 enabled
      wr(8'h00, 32'd10);
      wr(8'h04, 32'd13);
      wr(8'h08, 32'h4);
      wait_irq(400, "R5");
      chk(8'h00, 32'd13, "R5");
      chk(8'h08, 32'h5, "R5");
      // R8 writing zero keeps the event, writing one clears it
      wr(8'h08, 32'h4);
      chk(8'h08, 32'h5, "R8");
      wr(8'h08, 32'h5);
      chk(8'h08, 32'h4, "R8");
      report("R9", 32'(irq), 32'h0);

      // R6 alarm 1
      wr(8'h08, 32'h0);
      wr(8'h00, 32'd20);
      wr(8'h18, 32'd22);
      wr(8'h08, 32'h40);
      wait_irq(400, "R6");
      chk(8'h08, 32'h50, "R6");
      wr(8'h08, 32'h50);
      chk(8'h08, 32'h40, "R6");

      // R7 tick event
      wr(8'h08, 32'h8);
      wait_irq(400, "R7");
      chk(8'h08, 32'h2 | 32'h8, "R7");
      wr(8'h08, 32'h2);
      chk(8'h08, 32'h0, "R8");

      // R8/R11 reserved status bits, enables only remain
      wr(8'h1C, 32'd0);
      wr(8'h08, 32'hFFFF_FFFF);
      chk(8'h08, 32'h4C, "R8");
      wr(8'h08, 32'h0);

      // R11 field widths and unmapped offsets
      wr(8'h0C, 32'hFFFF_0005);
      chk(8'h0C, 32'h5, "R11");
      wr(8'h1C, 32'hFFFF_FFFE);
      chk(8'h1C, 32'h2, "R11");
      wr(8'h10, 32'hA5A5_A5A5);
      chk(8'h10, 32'h0, "R11");
      idle(20);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule